// File: doc/BRIEF.md
# SRAM Power-Cycle Sequencer

This block drives the low-level power controls of an SRAM array: an array-on enable, a clock-gate, an init hold line, and two pairs of power-switch enables (a large pair and a small pair). From the off state a power-on request runs a short bring-up sequence. The sequence ends with an init pulse that is taken while the clock is gated. After that the block reports ready.

When the array is ready, a power-cycle request takes it down cleanly. The block gates the clock, drops the array into sleep and re-opens the clock. It then closes all four switches and holds them for a programmable discharge time in milliseconds. Next it releases the small switches and then the large switches, each after its own settling dwell, and runs the bring-up sequence again. Two discharge values are presented at the ports: a short first-try value and a longer worst-case value. A select input picks between them when the request is accepted.

All dwells come from a microsecond prescaler derived from the `CLK_MHZ` parameter. They count whole cycles, and no dwell is ever shorter than its nominal value.

Top module: `sram_pwr_seq`

## Requirements
- R1: After reset, every control output is 0, `busy` is 0 and `ready` is 0. In the bench the control word is written {arr_on, clk_off, init_hold, psw_large[1:0], psw_small[1:0]}.
- R2: A power-on request in the off state produces five steps of one cycle each, with words 0110000, 1110000, 1010000, 1110000 and 1100000. The block then settles on 1000000 with `ready` high.
- R3: A power-cycle request in the ready state begins with three steps of one cycle each: 1110000 (clock gated), 0110000 (sleep) and 0010000 (clock re-opened).
- R4: The discharge step, word 0011111, lasts exactly max(M,1) * US_PER_MS * CLK_MHZ cycles. M is `long_ms` when `use_long` is 1 at the request and `short_ms` when it is 0. A value of 0 counts as one millisecond.
- R5: After discharge, the small switches are released first (word 0011100) for exactly SETTLE_US * CLK_MHZ cycles. The large switches are released next (word 0010000) for the same number of cycles.
- R6: After the large-switch dwell, the five power-up steps of R2 follow, and the block then returns to the ready word with `ready` high.
- R7: `busy` is 1 in every intermediate step and 0 in the off and ready states. `ready` is 1 only in the ready state. The two are never 1 together.
- R8: A request of either kind is ignored while busy. A power-on request in the ready state and a power-cycle request in the off state are also ignored.
- R9: The selected discharge time is latched when the request is accepted. Changes to `short_ms`, `long_ms` or `use_long` during a sequence do not change its timing.
- R10: Switch enables are only asserted while `arr_on` is 0, and a small switch is only asserted while both large switches are. `arr_on` rises and `init_hold` falls only while `clk_off` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_on_req | input | 1 | Power-on request pulse |
| pwr_cycle_req | input | 1 | Power-cycle request pulse |
| use_long | input | 1 | Selects the long discharge time for a power cycle |
| short_ms | input | MS_W | First-try discharge time in ms |
| long_ms | input | MS_W | Worst-case discharge time in ms |
| arr_on | output | 1 | Array power enable |
| clk_off | output | 1 | Array clock gate (1 = gated) |
| init_hold | output | 1 | Init held while 1, released by going to 0 |
| psw_large | output | 2 | Large power-switch pair enables |
| psw_small | output | 2 | Small power-switch pair enables |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | Array powered and initialised |

## Verification
Power cycles are swept over discharge values 0 to 3 on both the short and the long input, with the select toggled between runs. The measured drain length separates the two selections, shows the zero clamp, and exposes any off-by-one cycle in the prescaler chain. Every cycle of every sequence is compared against a step table that the bench builds itself. A wrong word, a wrong order or a wrong dwell therefore shows up as a miscompare at the exact cycle where it occurs. One run injects both requests and changes the discharge inputs in the middle of the drain. The off and ready states are also probed with the request that does not apply to them, so an accepted request shows up as a shifted or restarted sequence.

// File: rtl/sram_pwr_seq.sv
module sram_pwr_seq #(
  parameter int CLK_MHZ   = 50,
  parameter int US_PER_MS = 1000,
  parameter int SETTLE_US = 2,
  parameter int MS_W      = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr_on_req,
  input  logic            pwr_cycle_req,
  input  logic            use_long,
  input  logic [MS_W-1:0] short_ms,
  input  logic [MS_W-1:0] long_ms,
  output logic            arr_on,
  output logic            clk_off,
  output logic            init_hold,
  output logic [1:0]      psw_large,
  output logic [1:0]      psw_small,
  output logic            busy,
  output logic            ready
);
  localparam int PRE_W = $clog2(CLK_MHZ + 1);
  localparam int US_W  = $clog2(US_PER_MS + SETTLE_US + 1);

  typedef enum logic [3:0] {
    S_OFF, D_GATE, D_SLEEP, D_UNGATE, D_DRAIN, D_SMALL, D_LARGE,
    U_GATE, U_ON, U_UNGATE, P_GATE, P_REL, S_READY
  } st_t;

  st_t             st, nxt;
  logic [PRE_W-1:0] pre;
  logic [US_W-1:0]  us;
  logic [MS_W-1:0]  ms, ms_tgt;
  logic             tick, settle_done, drain_done, timed;
  logic [6:0]       word;

  assign tick        = pre == PRE_W'(CLK_MHZ - 1);
  assign settle_done = tick && us == US_W'(SETTLE_US - 1);
  assign drain_done  = tick && us == US_W'(US_PER_MS - 1) && ms == MS_W'(ms_tgt - 1'b1);
  assign timed       = st == D_DRAIN || st == D_SMALL || st == D_LARGE;

  always_comb begin
    nxt = st;
    unique case (st)
      S_OFF:    if (pwr_on_req) nxt = U_GATE;
      S_READY:  if (pwr_cycle_req) nxt = D_GATE;
      D_GATE:   nxt = D_SLEEP;
      D_SLEEP:  nxt = D_UNGATE;
      D_UNGATE: nxt = D_DRAIN;
      D_DRAIN:  if (drain_done) nxt = D_SMALL;
      D_SMALL:  if (settle_done) nxt = D_LARGE;
      D_LARGE:  if (settle_done) nxt = U_GATE;
      U_GATE:   nxt = U_ON;
      U_ON:     nxt = U_UNGATE;
      U_UNGATE: nxt = P_GATE;
      P_GATE:   nxt = P_REL;
      P_REL:    nxt = S_READY;
      default:  nxt = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_OFF;
      pre    <= '0;
      us     <= '0;
      ms     <= '0;
      ms_tgt <= MS_W'(1);
    end else begin
      st <= nxt;
      if (st == S_READY && pwr_cycle_req) begin
        if (use_long) ms_tgt <= (long_ms == '0) ? MS_W'(1) : long_ms;
        else          ms_tgt <= (short_ms == '0) ? MS_W'(1) : short_ms;
      end
      if (nxt != st || !timed) begin
        pre <= '0;
        us  <= '0;
        ms  <= '0;
      end else begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick) begin
          if (st == D_DRAIN && us == US_W'(US_PER_MS - 1)) begin
            us <= '0;
            ms <= ms + 1'b1;
          end else begin
            us <= us + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    unique case (st)
      D_GATE, U_ON, P_GATE: word = 7'b1110000;
      D_SLEEP, U_GATE:      word = 7'b0110000;
      D_UNGATE, D_LARGE:    word = 7'b0010000;
      D_DRAIN:              word = 7'b0011111;
      D_SMALL:              word = 7'b0011100;
      U_UNGATE:             word = 7'b1010000;
      P_REL:                word = 7'b1100000;
      S_READY:              word = 7'b1000000;
      default:              word = 7'b0000000;
    endcase
  end

  assign {arr_on, clk_off, init_hold, psw_large, psw_small} = word;
  assign ready = st == S_READY;
  assign busy  = st != S_READY && st != S_OFF;
endmodule

// File: rtl/sram_pwr_seq_chk.sv
module sram_pwr_seq_chk #(
  parameter int CLK_MHZ   = 50,
  parameter int SETTLE_US = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       arr_on,
  input logic       clk_off,
  input logic       init_hold,
  input logic [1:0] psw_large,
  input logic [1:0] psw_small,
  input logic       busy,
  input logic       ready
);
  localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ;

  int small_off_cnt, large_off_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      small_off_cnt <= 0;
      large_off_cnt <= 0;
    end else begin
      small_off_cnt <= (&psw_large && psw_small == 2'b00) ? small_off_cnt + 1 : 0;
      large_off_cnt <= (!arr_on && init_hold && !clk_off && psw_large == 2'b00 && psw_small == 2'b00)
                       ? large_off_cnt + 1 : 0;
    end
  end

  assert_busy_ready_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, ready}));
  assert_switch_only_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|psw_large || |psw_small) |-> !arr_on);
  assert_small_needs_large_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|psw_small) |-> &psw_large);
  assert_on_while_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arr_on) |-> clk_off);
  assert_init_rel_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_hold) |-> (clk_off && arr_on));
  assert_sleep_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arr_on) |-> clk_off);
  assert_small_dwell_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psw_large[0]) |-> small_off_cnt >= SETTLE_CYC);
  assert_large_dwell_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(clk_off) && !arr_on && $past(init_hold)) |-> large_off_cnt >= SETTLE_CYC);
  assert_ready_after_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(clk_off) && !$past(init_hold)));
endmodule

bind sram_pwr_seq sram_pwr_seq_chk #(.CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US)) u_chk (
  .clk(clk), .rst_n(rst_n), .arr_on(arr_on), .clk_off(clk_off), .init_hold(init_hold),
  .psw_large(psw_large), .psw_small(psw_small), .busy(busy), .ready(ready)
);

// File: tb/sim_sram_pwr_seq.sv
module sim_sram_pwr_seq;
  localparam int CLK_MHZ = 3, US_PER_MS = 4, SETTLE_US = 2, MS_W = 4;
  localparam int MS_CYC = CLK_MHZ * US_PER_MS;
  localparam int SET_CYC = CLK_MHZ * SETTLE_US;

  logic clk = 0, rst_n = 0;
  logic pwr_on_req = 0, pwr_cycle_req = 0, use_long = 0;
  logic [MS_W-1:0] short_ms = 0, long_ms = 0;
  logic arr_on, clk_off, init_hold, busy, ready;
  logic [1:0] psw_large, psw_small;
  int vecs = 0, errs = 0;

  always #10 clk = ~clk;

  sram_pwr_seq #(.CLK_MHZ(CLK_MHZ), .US_PER_MS(US_PER_MS), .SETTLE_US(SETTLE_US), .MS_W(MS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_cycle_req(pwr_cycle_req),
    .use_long(use_long), .short_ms(short_ms), .long_ms(long_ms), .arr_on(arr_on),
    .clk_off(clk_off), .init_hold(init_hold), .psw_large(psw_large), .psw_small(psw_small),
    .busy(busy), .ready(ready));

  task automatic chk(input logic [6:0] w, input logic b, input logic r, input string tag);
    logic [8:0] act, exp;
    act = {arr_on, clk_off, init_hold, psw_large, psw_small, busy, ready};
    exp = {w, b, r};
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: word/busy/ready actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Checks len consecutive cycles; optionally disturbs inputs mid-step (R8, R9).
  task automatic step(input logic [6:0] w, input int len, input string tag, input bit disturb);
    for (int i = 0; i < len; i++) begin
      chk(w, 1'b1, 1'b0, tag);
      if (disturb && i == 2) begin
        pwr_on_req = 1; pwr_cycle_req = 1;
        short_ms = ~short_ms; long_ms = ~long_ms; use_long = ~use_long;
      end else begin
        pwr_on_req = 0; pwr_cycle_req = 0;
      end
      @(negedge clk);
    end
  endtask

  task automatic bring_up(input string tag);
    step(7'b0110000, 1, {tag, " R2 gate"}, 0);
    step(7'b1110000, 1, {tag, " R2 on"}, 0);
    step(7'b1010000, 1, {tag, " R2 ungate"}, 0);
    step(7'b1110000, 1, {tag, " R2 pulse gate"}, 0);
    step(7'b1100000, 1, {tag, " R2 init release"}, 0);
    chk(7'b1000000, 1'b0, 1'b1, {tag, " R7 ready"});
  endtask

  task automatic hold_idle(input logic [6:0] w, input logic r, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      chk(w, 1'b0, r, tag);
      @(negedge clk);
    end
  endtask

  task automatic cycle(input logic [MS_W-1:0] s, input logic [MS_W-1:0] l, input bit sel, input bit disturb);
    int m;
    short_ms = s; long_ms = l; use_long = sel;
    m = sel ? int'(l) : int'(s);
    if (m == 0) m = 1;
    pwr_cycle_req = 1;
    @(negedge clk);
    pwr_cycle_req = 0;
    step(7'b1110000, 1, "R3 clock gate", 0);
    step(7'b0110000, 1, "R3 sleep", 0);
    step(7'b0010000, 1, "R3 clock reopen", 0);
    step(7'b0011111, m * MS_CYC, disturb ? "R4 R8 R9 drain" : "R4 drain", disturb);
    pwr_on_req = 0; pwr_cycle_req = 0;
    step(7'b0011100, SET_CYC, "R5 small released", 0);
    step(7'b0010000, SET_CYC, "R5 large released", 0);
    bring_up("R6");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(7'b0000000, 1'b0, 1'b0, "R1 reset");
    rst_n = 1;
    @(negedge clk);
    chk(7'b0000000, 1'b0, 1'b0, "R1 after release");
    pwr_cycle_req = 1;
    @(negedge clk);
    pwr_cycle_req = 0;
    hold_idle(7'b0000000, 1'b0, 4, "R8 cycle in off ignored");
    pwr_on_req = 1;
    @(negedge clk);
    pwr_on_req = 0;
    bring_up("R2");
    @(negedge clk);
    pwr_on_req = 1;
    @(negedge clk);
    pwr_on_req = 0;
    hold_idle(7'b1000000, 1'b1, 4, "R8 on in ready ignored");
    for (int ms = 0; ms < 4; ms++) begin
      cycle(MS_W'(ms), MS_W'(ms + 2), 1'b0, 0);
      @(negedge clk);
      cycle(MS_W'(ms + 1), MS_W'(ms), 1'b1, 0);
      @(negedge clk);
    end
    cycle(4'd1, 4'd3, 1'b1, 1);
    @(negedge clk);
    cycle(4'd2, 4'd0, 1'b0, 1);
    hold_idle(7'b1000000, 1'b1, 3, "R7 R8 stable ready");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule